// File: doc/BRIEF.md
# AUX Request Frame Sequencer

This block turns one DisplayPort-style AUX request into the ordered byte stream that a transmit buffer expects, and then tells the transmitter how many bytes to send and when to start. A request arrives on a valid/ready handshake. It carries a family flag (native or I2C-over-AUX), a direction flag, a middle-of-transaction flag, a 20-bit address and a payload length. The block picks the 4-bit command from the three flags. It emits three address-bearing header bytes. When the length is non-zero it adds a length byte. For writes it then forwards the payload bytes from a second valid/ready stream.

The output byte stream is valid/ready. The block holds a byte and its valid flag until the buffer accepts it, so the buffer may apply back-pressure at any cycle. The payload stream is passed straight through during the data phase: `pay_ready` follows `tx_ready`, and a stall on either side stalls the other. The payload source must hold `pay_data` while `pay_valid` is high and `pay_ready` is low. Reads consume nothing from the payload stream.

Before any byte of a new frame is offered, a pending done status from the transmitter must clear: the block raises `done_ack` until it does. After the last byte is accepted, the block pulses `tx_go` once, with the byte count on `tx_count`. A write request longer than the permitted maximum is refused at the handshake with a one-cycle `req_err`, and nothing is sent.

Top module: `aux_req_framer`

## Requirements
- R1: The upper nibble of the first byte is the command: native write 0x8, native read 0x9, I2C write 0x0, I2C read 0x1; for I2C requests with the middle-of-transaction flag set, bit 2 of the nibble is also set (0x4 write, 0x5 read).
- R2: The lower nibble of the first byte is address bits 19..16; the second byte is address bits 15..8 and the third byte is address bits 7..0, sent in that order.
- R3: A fourth byte equal to length minus one follows the address bytes exactly when the length is non-zero; with zero length the header is three bytes.
- R4: `tx_count` at the `tx_go` pulse equals 3 for zero length or 4 otherwise, plus the length for writes only.
- R5: For writes, exactly `length` payload bytes are sent after the header in arrival order; reads take no byte from the payload stream and send none.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged on the next cycle.
- R7: While `done_status` is high before a frame starts, `done_ack` is high and no byte is offered; the frame starts once `done_status` is low.
- R8: `tx_go` is high for exactly one cycle per accepted request, in the cycle after the last byte is accepted.
- R9: A write with length above MAX_WR (16) gives a one-cycle `req_err` the cycle after the handshake, offers no byte and no `tx_go`; reads of any length and writes of exactly MAX_WR are accepted.
- R10: `req_ready` is low from the handshake of an accepted request until the cycle after its `tx_go`.
- R11: The middle-of-transaction flag has no effect on native requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_i2c | input | 1 | 1 = I2C-over-AUX family, 0 = native |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mot | input | 1 | Middle-of-transaction flag (I2C only) |
| req_addr | input | 20 | Request address |
| req_len | input | LEN_W | Payload length in bytes |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte taken |
| pay_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Transmit buffer accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_count | output | CNT_W | Number of bytes in the frame |
| tx_go | output | 1 | One-cycle start strobe |
| done_status | input | 1 | Pending done status from transmitter |
| done_ack | output | 1 | Acknowledge for pending done status |
| req_err | output | 1 | One-cycle refusal of an over-long write |

## Verification
A wrong header index or a wrong end-of-header decision shows up at once as a missing, repeated or extra byte on `tx_data`, and as a mismatch between the bytes accepted and `tx_count` at the strobe. A stuck data counter shows up as payload bytes taken from the stream on a read, or as a `tx_go` that comes early, late, or never. A broken wait state shows up as a byte offered while `done_status` is still high. A wrong refusal decision shows up within one cycle of the handshake as a missing or false `req_err` at the 16/17 and read-length boundaries. Stalls on `tx_ready` check that a held byte does not change while the buffer is not ready.

// File: rtl/aux_framer_pkg.sv
package aux_framer_pkg;
  localparam int ADDR_W = 20;
  localparam int BYTE_W = 8;

  // command nibbles (upper half of the first frame byte)
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;
  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT_BIT = 4'h4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR,
    ST_DATA,
    ST_GO
  } seq_state_t;
endpackage

// File: rtl/aux_cmd_encode.sv
module aux_cmd_encode
  import aux_framer_pkg::*;
(
  input  logic       i2c_i,
  input  logic       write_i,
  input  logic       mot_i,
  output logic [3:0] cmd_o,
  output logic       is_write_o
);
  logic [3:0] base_cmd;

  always_comb begin
    unique case ({i2c_i, write_i})
      2'b01:   base_cmd = CMD_NAT_WR;
      2'b00:   base_cmd = CMD_NAT_RD;
      2'b11:   base_cmd = CMD_I2C_WR;
      default: base_cmd = CMD_I2C_RD;
    endcase
    // continuing variant exists only in the I2C family
    cmd_o = (i2c_i && mot_i) ? (base_cmd | CMD_MOT_BIT) : base_cmd;
  end

  // every write variant (native, I2C, I2C continuing) carries payload
  assign is_write_o = write_i;
endmodule

// File: rtl/aux_hdr_builder.sv
module aux_hdr_builder
  import aux_framer_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 5
) (
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              is_write_i,
  input  logic [1:0]        idx_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [2:0]        hdr_n_o,
  output logic [CNT_W-1:0]  total_o
);
  localparam int SUM_W = LEN_W + 1;

  logic              len_nz;
  logic [SUM_W-1:0]  base_n;
  logic [SUM_W-1:0]  data_n;
  logic [SUM_W-1:0]  sum;

  assign len_nz  = (len_i != '0);
  assign hdr_n_o = len_nz ? 3'd4 : 3'd3;

  always_comb begin
    unique case (idx_i)
      2'd0:    byte_o = {cmd_i, addr_i[19:16]};
      2'd1:    byte_o = addr_i[15:8];
      2'd2:    byte_o = addr_i[7:0];
      default: byte_o = BYTE_W'(len_i - 1'b1);
    endcase
  end

  assign base_n  = SUM_W'(hdr_n_o);
  assign data_n  = is_write_i ? {1'b0, len_i} : '0;
  assign sum     = base_n + data_n;
  assign total_o = CNT_W'(sum);
endmodule

// File: rtl/aux_frame_ctrl.sv
module aux_frame_ctrl
  import aux_framer_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 5,
  parameter int MAX_WR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_i2c,
  input  logic              req_write,
  input  logic              req_mot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              lat_i2c,
  output logic              lat_write,
  output logic              lat_mot,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [LEN_W-1:0]  lat_len,
  input  logic [BYTE_W-1:0] hdr_byte,
  input  logic [2:0]        hdr_n,
  input  logic [CNT_W-1:0]  total,
  output logic [1:0]        hdr_idx,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [BYTE_W-1:0] pay_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_go,
  input  logic              done_status,
  output logic              done_ack,
  output logic              req_err
);
  seq_state_t         state;
  logic [LEN_W-1:0]   dcnt;
  logic [CNT_W-1:0]   count_q;
  logic               err_q;
  logic               accept;
  logic               too_long;
  logic               hdr_last;
  logic               data_last;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign too_long  = req_write && ({1'b0, req_len} > (LEN_W+1)'(MAX_WR));
  assign hdr_last  = ({1'b0, hdr_idx} == (hdr_n - 3'd1));
  assign data_last = (dcnt == (lat_len - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_i2c   <= 1'b0;
      lat_write <= 1'b0;
      lat_mot   <= 1'b0;
      lat_addr  <= '0;
      lat_len   <= '0;
      hdr_idx   <= 2'd0;
      dcnt      <= '0;
      count_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (too_long) begin
              err_q <= 1'b1;
            end else begin
              lat_i2c   <= req_i2c;
              lat_write <= req_write;
              lat_mot   <= req_mot;
              lat_addr  <= req_addr;
              lat_len   <= req_len;
              state     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          hdr_idx <= 2'd0;
          dcnt    <= '0;
          count_q <= total;
          if (!done_status) state <= ST_HDR;
        end
        ST_HDR: begin
          if (tx_ready) begin
            if (hdr_last) begin
              hdr_idx <= 2'd0;
              state   <= (lat_write && (lat_len != '0)) ? ST_DATA : ST_GO;
            end else begin
              hdr_idx <= hdr_idx + 2'd1;
            end
          end
        end
        ST_DATA: begin
          if (pay_valid && tx_ready) begin
            if (data_last) state <= ST_GO;
            else           dcnt  <= dcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done_ack  = (state == ST_WAIT) && done_status;
  assign tx_valid  = (state == ST_HDR) || ((state == ST_DATA) && pay_valid);
  assign tx_data   = (state == ST_DATA) ? pay_data : hdr_byte;
  assign pay_ready = (state == ST_DATA) && tx_ready;
  assign tx_go     = (state == ST_GO);
  assign tx_count  = count_q;
  assign req_err   = err_q;

  // R6
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R8
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

  // R10
  ready_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> req_ready);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !too_long) |=> !req_ready);

  // R7
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack |-> (!tx_valid && !tx_go));

  // R9
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && !tx_valid && !tx_go));

  // R3
  len_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HDR) && (hdr_idx == 2'd3)) |-> (lat_len != '0));

  // R5
  read_no_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> lat_write);

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> (count_q >= CNT_W'(hdr_n)));
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_framer_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int MAX_WR = 16,
  localparam int CNT_W = $clog2(MAX_WR + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_i2c,
  input  logic              req_write,
  input  logic              req_mot,
  input  logic [19:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_go,
  input  logic              done_status,
  output logic              done_ack,
  output logic              req_err
);
  logic              lat_i2c;
  logic              lat_write;
  logic              lat_mot;
  logic [ADDR_W-1:0] lat_addr;
  logic [LEN_W-1:0]  lat_len;
  logic [3:0]        cmd;
  logic              is_write;
  logic [1:0]        hdr_idx;
  logic [BYTE_W-1:0] hdr_byte;
  logic [2:0]        hdr_n;
  logic [CNT_W-1:0]  total;

  aux_cmd_encode u_enc (
    .i2c_i      (lat_i2c),
    .write_i    (lat_write),
    .mot_i      (lat_mot),
    .cmd_o      (cmd),
    .is_write_o (is_write)
  );

  aux_hdr_builder #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdr (
    .cmd_i      (cmd),
    .addr_i     (lat_addr),
    .len_i      (lat_len),
    .is_write_i (is_write),
    .idx_i      (hdr_idx),
    .byte_o     (hdr_byte),
    .hdr_n_o    (hdr_n),
    .total_o    (total)
  );

  aux_frame_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_WR(MAX_WR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_i2c     (req_i2c),
    .req_write   (req_write),
    .req_mot     (req_mot),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .lat_i2c     (lat_i2c),
    .lat_write   (lat_write),
    .lat_mot     (lat_mot),
    .lat_addr    (lat_addr),
    .lat_len     (lat_len),
    .hdr_byte    (hdr_byte),
    .hdr_n       (hdr_n),
    .total       (total),
    .hdr_idx     (hdr_idx),
    .pay_valid   (pay_valid),
    .pay_ready   (pay_ready),
    .pay_data    (pay_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_count    (tx_count),
    .tx_go       (tx_go),
    .done_status (done_status),
    .done_ack    (done_ack),
    .req_err     (req_err)
  );
endmodule

// File: tb/test_aux_req_framer.sv
module test_aux_req_framer;
  localparam int CW = $clog2(16 + 5);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic        req_i2c = 1'b0, req_write = 1'b0, req_mot = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        pay_valid = 1'b0, pay_ready;
  logic [7:0]  pay_data = '0;
  logic        tx_valid, tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic [CW-1:0] tx_count;
  logic        tx_go, done_status = 1'b0, done_ack, req_err;

  aux_req_framer i_aux_req_framer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_i2c(req_i2c), .req_write(req_write), .req_mot(req_mot),
    .req_addr(req_addr), .req_len(req_len), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .pay_data(pay_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_count(tx_count),
    .tx_go(tx_go), .done_status(done_status), .done_ack(done_ack),
    .req_err(req_err)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  logic [7:0] rx [0:63];
  int rx_n, go_n, err_n, pay_taken, viol, stab_err, rdy_err, ack_n;
  int last_tx_cyc, go_cyc, go_cnt;
  bit prev_stall, pay_hs, req_hs, ack_seen, busy, exp_rej;
  logic [7:0] prev_data;

  // driver state
  logic [7:0] pay_mem [0:255];
  int pay_idx, pay_n;
  bit pay_en, stall_en;
  logic [7:0] lfsr = 8'h5B;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (rx_n < 64) rx[rx_n] = tx_data;
        rx_n++;
        last_tx_cyc = cyc;
      end
      if (pay_valid && pay_ready) begin pay_hs = 1; pay_taken++; end
      if (err) err_n++;
      if (done_ack) begin ack_seen = 1; ack_n++; end
      if (done_status && tx_valid) viol++;
      if (prev_stall && (!tx_valid || tx_data != prev_data)) stab_err++;
      prev_stall = tx_valid && !tx_ready;
      prev_data = tx_data;
      if (busy && req_ready) rdy_err++;
      if (req_valid && req_ready) begin req_hs = 1; if (!exp_rej) busy = 1; end
      if (tx_go) begin go_n++; go_cyc = cyc; go_cnt = int'(tx_count); busy = 0; end
    end
  end
  wire err = req_err;

  always @(posedge clk) begin
    #2;
    if (pay_hs) begin pay_idx++; pay_hs = 0; end
    pay_valid = pay_en && (pay_idx < pay_n);
    pay_data = (pay_idx < 256) ? pay_mem[pay_idx] : 8'h00;
    if (stall_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = lfsr[0] | lfsr[2];
    end else tx_ready = 1'b1;
    if (ack_seen) begin done_status = 1'b0; ack_seen = 0; end
  end

  task automatic run_req(input string name, input bit i2c, input bit wr,
                         input bit mot, input logic [19:0] addr, input int len,
                         input bit stall, input bit pend);
    logic [7:0] exp [0:63];
    int exp_n, exp_cnt, t;
    logic [3:0] cmd;
    exp_rej = wr && (len > 16);
    rx_n = 0; go_n = 0; err_n = 0; pay_taken = 0; viol = 0; stab_err = 0;
    rdy_err = 0; ack_n = 0; req_hs = 0; go_cyc = -1; last_tx_cyc = -9;
    pay_en = 0;
    for (int i = 0; i < 256; i++) pay_mem[i] = 8'(8'h3C + i * 7 + len);
    @(posedge clk); #3;
    pay_idx = 0; pay_n = wr ? len : 1; pay_en = 1; stall_en = stall;
    if (pend) done_status = 1'b1;
    req_i2c = i2c; req_write = wr; req_mot = mot; req_addr = addr;
    req_len = 8'(len); req_valid = 1'b1;
    t = 0;
    do begin @(posedge clk); #3; t++; end while (!req_hs && t < 100);
    req_valid = 1'b0;
    t = 0;
    while (go_n == 0 && err_n == 0 && t < 3000) begin @(posedge clk); #3; t++; end
    repeat (6) @(posedge clk);
    #3;
    pay_en = 0; stall_en = 0;
    // expected frame
    if (i2c) cmd = {1'b0, mot, 1'b0, ~wr};
    else     cmd = {1'b1, 2'b00, ~wr};
    exp[0] = {cmd, addr[19:16]}; exp[1] = addr[15:8]; exp[2] = addr[7:0];
    exp_n = 3;
    if (len != 0) begin exp[3] = 8'(len - 1); exp_n = 4; end
    exp_cnt = exp_n + (wr ? len : 0);
    if (wr) for (int i = 0; i < len && exp_n < 64; i++) begin
      exp[exp_n] = pay_mem[i]; exp_n++;
    end
    if (exp_rej) begin
      chk(err_n == 1, "R9", {name, " err pulse"}, err_n, 1);
      chk(rx_n == 0, "R9", {name, " no bytes"}, rx_n, 0);
      chk(go_n == 0, "R9", {name, " no go"}, go_n, 0);
      chk(pay_taken == 0, "R9", {name, " no payload"}, pay_taken, 0);
    end else begin
      chk(err_n == 0, "R9", {name, " no err"}, err_n, 0);
      chk(go_n == 1, "R8", {name, " one go"}, go_n, 1);
      chk(go_cyc == last_tx_cyc + 1, "R8", {name, " go after last byte"},
          go_cyc, last_tx_cyc + 1);
      chk(rx_n == exp_n, "R3", {name, " byte total"}, rx_n, exp_n);
      chk(go_cnt == exp_cnt, "R4", {name, " tx_count"}, go_cnt, exp_cnt);
      for (int i = 0; i < exp_n && i < rx_n; i++)
        chk(rx[i] == exp[i], (i == 0) ? "R1" : (i < 3) ? "R2" : (i == 3) ? "R3" : "R5",
            $sformatf("%s byte %0d", name, i), rx[i], exp[i]);
      chk(pay_taken == (wr ? len : 0), "R5", {name, " payload taken"},
          pay_taken, wr ? len : 0);
      chk(stab_err == 0, "R6", {name, " held byte stable"}, stab_err, 0);
      chk(rdy_err == 0, "R10", {name, " ready low while busy"}, rdy_err, 0);
      chk(viol == 0, "R7", {name, " no byte while done pending"}, viol, 0);
      if (pend) chk(ack_n > 0, "R7", {name, " done_ack seen"}, ack_n, 1);
    end
    exp_rej = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
    chk(tx_valid == 1'b0, "R8", "reset tx_valid", tx_valid, 0);
    chk(tx_go == 1'b0, "R8", "reset tx_go", tx_go, 0);
    chk(req_err == 1'b0, "R9", "reset req_err", req_err, 0);
    chk(done_ack == 1'b0, "R7", "reset done_ack", done_ack, 0);
  endtask

  // R1 R2 R3 R5: native read, 16 bytes, no stall
  task automatic t_native_read;   run_req("nat_rd",   0, 0, 0, 20'h12345, 16, 0, 0); endtask
  // R5 R6: native write under back-pressure
  task automatic t_native_write;  run_req("nat_wr",   0, 1, 0, 20'hA0F0C, 5, 1, 0); endtask
  // R1: I2C write continuing
  task automatic t_i2c_wr_mot;    run_req("i2c_wrm",  1, 1, 1, 20'h00050, 1, 1, 0); endtask
  // R3: I2C read continuing, zero length, no length byte
  task automatic t_i2c_rd_mot;    run_req("i2c_rdm",  1, 0, 1, 20'h00050, 0, 0, 0); endtask
  // R1: I2C read
  task automatic t_i2c_read;      run_req("i2c_rd",   1, 0, 0, 20'hFFFFF, 3, 1, 0); endtask
  // R11: continuing flag on a native write has no effect
  task automatic t_native_mot;    run_req("nat_mot",  0, 1, 1, 20'h60001, 2, 0, 0); endtask
  // R4: address-only write
  task automatic t_write_len0;    run_req("wr_len0",  0, 1, 0, 20'h00F00, 0, 0, 0); endtask
  // R9: over-long write refused, then limit accepted
  task automatic t_reject;
    run_req("wr_17",  0, 1, 0, 20'h11111, 17, 0, 0);
    run_req("wr_16",  1, 1, 0, 20'h22222, 16, 1, 0);
  endtask
  // R9: long reads are not refused
  task automatic t_read_long;     run_req("rd_200",   0, 0, 0, 20'h80000, 200, 1, 0); endtask
  // R7: pending done status acknowledged first
  task automatic t_pending_done;  run_req("pend",     0, 1, 0, 20'h0ABCD, 4, 0, 1); endtask

  initial begin
    rx_n = 0; go_n = 0; err_n = 0; pay_idx = 0; pay_n = 0; busy = 0;
    pay_en = 0; stall_en = 0; exp_rej = 0; ack_seen = 0; pay_hs = 0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    t_reset();
    t_native_read();
    t_native_write();
    t_i2c_wr_mot();
    t_i2c_rd_mot();
    t_i2c_read();
    t_native_mot();
    t_write_len0();
    t_reject();
    t_read_long();
    t_pending_done();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule